// File: doc/BRIEF.md
# Conversion Code Output Formatter

This block sits between a two-step converter core and its parallel output pins. The core delivers a fresh 10-bit code on every sample clock. The block carries each code through a short register pipeline so that it arrives on the output bus a fixed number of clocks after it was captured. On the way out it rewrites the code into the format the system expects.

Two inversion controls reshape each word. One acts on the nine lower bits and the other acts only on the MSB. With them the bus can present straight binary, fully inverted binary, offset two's complement (MSB inverted only), or the inverse of that. A pattern-force control replaces the data with a fixed alternating word, which is useful for board-level bus testing. That word still passes through both inversion controls.

When the calibration scheduler borrows the fine comparators, it raises a hold request alongside the affected codes. The hold request travels down the pipeline with its code, so the five lower output bits stay frozen for exactly the affected samples while the upper five bits keep moving. The pad drive enable is produced as a separate output so that the pad ring can tri-state the bus.

Top module: `adc_fmt_pipe`

## Requirements
- R1: A code applied on `raw_code` at rising edge n is shown on `q` from just after edge n+2 until edge n+3, passing through three register stages. Each later edge presents the next code, so one code leaves per clock.
- R2: When `low_inv` is high at the edge that loads `q`, bits 8..0 of the loaded word are the bitwise inverse of the source bits. When it is low, they are copied unchanged.
- R3: When `msb_inv` is high at the edge that loads `q`, bit 9 is inverted. When it is low, bit 9 is copied unchanged. For example, with only `msb_inv` set, code 512 leaves as 0 and code 511 leaves as 1023, which is offset two's complement.
- R4: When `force_pat` is high at the edge that loads `q`, the source word is the fixed pattern 10'b01_0101_0101, where bit 0 is 1 and the bits alternate upward. This pattern is then inverted by `low_inv` and `msb_inv` exactly as data would be.
- R5: When `force_pat` is low, the source word is the delayed conversion code.
- R6: `bus_drive` is high whenever `oe_n` is low and low whenever `oe_n` is high, with no clock delay. `q` keeps updating regardless of `oe_n`.
- R7: A code applied together with `hold_req` high does not change `q[4:0]` on the edge that brings it to the output; those bits keep their previous value. `q[9:5]` update normally on that edge.
- R8: A high `rst` at a rising edge clears `q` and every pipeline stage, including the travelling hold flags, to zero.
- R9: With both inversions off and the pattern off, code 0 leaves as 0, code 1023 leaves as 1023, and codes 511 and 512 leave unchanged on either side of the MSB boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| raw_code | input | 10 | Conversion code from the core, one per clock |
| hold_req | input | 1 | Calibration borrow flag travelling with `raw_code` |
| low_inv | input | 1 | Inverts output bits 8..0 when high |
| msb_inv | input | 1 | Inverts output bit 9 when high |
| force_pat | input | 1 | Replaces data with the alternating test word when high |
| oe_n | input | 1 | Output enable, active low |
| q | output | 10 | Formatted, registered output word |
| bus_drive | output | 1 | High when the pads should drive `q`, low for high impedance |

## Verification
The assertions check the pipeline arithmetic on every cycle once the pipeline has filled. They relate each `q` bit to the code applied three edges earlier and to the inversion and pattern controls of the previous edge, and they confirm that the low field stays frozen whenever a held code reaches the output. The bench scenarios are needed for the cases the properties cannot see. These are the absolute latency of a single isolated code, the boundary codes of each output format, the frozen bits lining up with a four-sample borrow window, the drive enable following `oe_n` while data keeps flowing, and a reset in the middle of a stream clearing everything.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int unsigned CODE_W = 10;
  typedef logic [CODE_W-1:0] code_t;

  // Alternating board-test word: even bit positions are 1.
  function automatic code_t alt_pattern();
    code_t w;
    for (int b = 0; b < CODE_W; b++) w[b] = (b % 2 == 0);
    return w;
  endfunction

  // XOR mask built from the two independent inversion controls.
  function automatic code_t inv_mask(input logic low_flip, input logic msb_flip);
    code_t m;
    m = {CODE_W{low_flip}};
    m[CODE_W-1] = msb_flip;
    return m;
  endfunction

  function automatic code_t format_word(input code_t src, input logic pat,
                                        input logic low_flip, input logic msb_flip);
    return (pat ? alt_pattern() : src) ^ inv_mask(low_flip, msb_flip);
  endfunction
endpackage

// File: rtl/adc_fmt_delay.sv
module adc_fmt_delay #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_chain
      logic [DEPTH-1:0][W-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) begin
          stg <= '0;
        end else begin
          stg[0] <= din;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign dout = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/adc_fmt_shape.sv
module adc_fmt_shape
  import adc_fmt_pkg::*;
(
  input  code_t src,
  input  logic  pat,
  input  logic  low_flip,
  input  logic  msb_flip,
  output code_t word
);
  assign word = format_word(src, pat, low_flip, msb_flip);
endmodule

// File: rtl/adc_fmt_outreg.sv
module adc_fmt_outreg
  import adc_fmt_pkg::*;
#(
  parameter int unsigned HOLD_W = 5
) (
  input  logic  clk,
  input  logic  rst,
  input  code_t d,
  input  logic  hold,
  output code_t q
);
  localparam int unsigned HI_LSB = HOLD_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q[CODE_W-1:HI_LSB] <= d[CODE_W-1:HI_LSB];
      if (!hold) q[HOLD_W-1:0] <= d[HOLD_W-1:0];
    end
  end

  // R7: a held sample leaves the low field untouched on its output edge
  assert_low_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(q[HOLD_W-1:0]));
endmodule

// File: rtl/adc_fmt_pipe.sv
module adc_fmt_pipe
  import adc_fmt_pkg::*;
#(
  parameter int unsigned HOLD_W  = 5,
  parameter int unsigned LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] raw_code,
  input  logic              hold_req,
  input  logic              low_inv,
  input  logic              msb_inv,
  input  logic              force_pat,
  input  logic              oe_n,
  output logic [CODE_W-1:0] q,
  output logic              bus_drive
);
  localparam int unsigned MSB     = CODE_W - 1;
  localparam int unsigned DLY     = LATENCY - 1;
  localparam int unsigned FILL_W  = $clog2(LATENCY + 1);

  // Named internal events
  logic              hold_d;
  code_t             code_d;
  code_t             fmt_word;
  logic [FILL_W-1:0] fill_cnt;
  logic              pipe_full;

  adc_fmt_delay #(.W(CODE_W + 1), .DEPTH(DLY)) u_delay (
    .clk  (clk),
    .rst  (rst),
    .din  ({hold_req, raw_code}),
    .dout ({hold_d, code_d})
  );

  adc_fmt_shape u_shape (
    .src      (code_d),
    .pat      (force_pat),
    .low_flip (low_inv),
    .msb_flip (msb_inv),
    .word     (fmt_word)
  );

  adc_fmt_outreg #(.HOLD_W(HOLD_W)) u_out (
    .clk  (clk),
    .rst  (rst),
    .d    (fmt_word),
    .hold (hold_d),
    .q    (q)
  );

  assign bus_drive = !oe_n;

  // Consecutive non-reset edges, saturating at LATENCY; guards the checks
  always_ff @(posedge clk) begin
    if (rst) fill_cnt <= '0;
    else if (fill_cnt != FILL_W'(LATENCY)) fill_cnt <= fill_cnt + 1'b1;
  end
  assign pipe_full = (fill_cnt == FILL_W'(LATENCY));

  // R8: reset empties the output register
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (q == '0));

  generate
    if (LATENCY == 3) begin : g_chk3
      // R1 R3: MSB follows the code from three edges back, flipped by msb_inv
      assert_msb_path_R3: assert property (@(posedge clk) disable iff (rst)
        (pipe_full && !$past(force_pat)) |->
          (q[MSB] == ($past(raw_code[MSB], 3) ^ $past(msb_inv))));
      // R1 R2 R5: low nine bits follow the code when no hold applied
      assert_low_path_R2: assert property (@(posedge clk) disable iff (rst)
        (pipe_full && !$past(force_pat) && !$past(hold_req, 3)) |->
          (q[MSB-1:0] == ($past(raw_code[MSB-1:0], 3) ^ {(CODE_W-1){$past(low_inv)}})));
      // R4: forced pattern goes through the same inversions
      assert_pattern_R4: assert property (@(posedge clk) disable iff (rst)
        (pipe_full && $past(force_pat) && !$past(hold_req, 3)) |->
          (q == (alt_pattern() ^ inv_mask($past(low_inv), $past(msb_inv)))));
      // R7: upper field keeps moving while the low field is frozen
      assert_upper_live_R7: assert property (@(posedge clk) disable iff (rst)
        (pipe_full && !$past(force_pat) && $past(hold_req, 3)) |->
          (q[MSB-1:HOLD_W] == ($past(raw_code[MSB-1:HOLD_W], 3) ^ {(MSB-HOLD_W){$past(low_inv)}})));
    end
  endgenerate
endmodule

// File: tb/adc_fmt_pipe_bench.sv
module adc_fmt_pipe_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] raw_code;
  logic       hold_req, low_inv, msb_inv, force_pat, oe_n;
  logic [9:0] q;
  logic       bus_drive;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  adc_fmt_pipe u_adc_fmt_pipe (
    .clk(clk), .rst(rst), .raw_code(raw_code), .hold_req(hold_req),
    .low_inv(low_inv), .msb_inv(msb_inv), .force_pat(force_pat), .oe_n(oe_n),
    .q(q), .bus_drive(bus_drive)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected word built bit by bit from the requirement text
  function automatic logic [9:0] expect_word(input logic [9:0] c, input logic li,
                                             input logic mi, input logic fp);
    logic [9:0] w;
    for (int b = 0; b < 10; b++) begin
      logic v;
      v = fp ? ((b & 1) == 0) : c[b];
      w[b] = v ^ ((b == 9) ? mi : li);
    end
    return w;
  endfunction

  // Streams n codes; code i = (base + i*step) mod 1024; held for indices in [hf, hf+hl)
  task automatic run_stream(input string req, input int n, input int base, input int step,
                            input logic li, input logic mi, input logic fp,
                            input int hf, input int hl);
    logic [9:0] hist [64];
    logic       hh   [64];
    logic [9:0] prev = '0;
    logic [9:0] exp;
    low_inv = li; msb_inv = mi; force_pat = fp;
    for (int i = 0; i < n + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        int k = i - 3;
        exp = expect_word(hist[k], li, mi, fp);
        if (hh[k]) exp[4:0] = prev[4:0];
        check(req, q, exp);
        check("R6", {9'b0, bus_drive}, {9'b0, !oe_n});
        prev = exp;
      end
      if (i < n) begin
        hist[i] = 10'((base + i * step) & 1023);
        hh[i]   = (i >= hf) && (i < hf + hl);
        raw_code = hist[i];
        hold_req = hh[i];
      end else begin
        hold_req = 1'b0;
      end
    end
  endtask

  task automatic t_reset_state();
    rst = 1'b1; raw_code = 10'h3FF; hold_req = 1'b1;
    low_inv = 1'b0; msb_inv = 1'b0; force_pat = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 reset q", q, 10'h000);
    check("R6 drive at reset", {9'b0, bus_drive}, 10'h001);
    rst = 1'b0; raw_code = '0; hold_req = 1'b0;
  endtask

  task automatic t_latency_R1();
    raw_code = '0;
    repeat (4) @(negedge clk);
    raw_code = 10'h2A5;             // captured at edge n
    @(negedge clk); raw_code = '0;
    check("R1 after n", q, 10'h000);
    @(negedge clk); check("R1 after n+1", q, 10'h000);
    @(negedge clk); check("R1 after n+2", q, 10'h2A5);
    @(negedge clk); check("R1 after n+3", q, 10'h000);
  endtask

  task automatic t_reset_mid_R8();
    run_stream("R8 pre", 6, 100, 77, 1'b0, 1'b0, 1'b0, 99, 0);
    raw_code = 10'h155; hold_req = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid-stream clear", q, 10'h000);
    @(negedge clk);
    rst = 1'b0; raw_code = '0; hold_req = 1'b0;
    @(negedge clk); check("R8 stage clear 1", q, 10'h000);
    @(negedge clk); check("R8 stage clear 2", q, 10'h000);
  endtask

  initial begin
    t_reset_state();
    t_latency_R1();
    run_stream("R9 straight boundary", 6, 510, 1, 1'b0, 1'b0, 1'b0, 99, 0);
    run_stream("R9 straight ends", 4, 0, 1023, 1'b0, 1'b0, 1'b0, 99, 0);
    run_stream("R5 data ramp", 10, 3, 341, 1'b0, 1'b0, 1'b0, 99, 0);
    run_stream("R2 low inverted", 8, 7, 133, 1'b1, 1'b0, 1'b0, 99, 0);
    run_stream("R3 offset twos", 6, 510, 1, 1'b0, 1'b1, 1'b0, 99, 0);
    run_stream("R2 R3 both inverted", 6, 510, 1, 1'b1, 1'b1, 1'b0, 99, 0);
    run_stream("R4 pattern plain", 4, 9, 200, 1'b0, 1'b0, 1'b1, 99, 0);
    run_stream("R4 pattern low inv", 4, 9, 200, 1'b1, 1'b0, 1'b1, 99, 0);
    run_stream("R4 pattern msb inv", 4, 9, 200, 1'b0, 1'b1, 1'b1, 99, 0);
    run_stream("R7 hold window", 14, 21, 97, 1'b0, 1'b0, 1'b0, 4, 4);
    run_stream("R7 hold inverted", 12, 500, 61, 1'b1, 1'b1, 1'b0, 3, 4);
    oe_n = 1'b1;
    run_stream("R6 data while tristated", 6, 44, 55, 1'b0, 1'b0, 1'b0, 99, 0);
    oe_n = 1'b0;
    #1 check("R6 drive restored", {9'b0, bus_drive}, 10'h001);
    t_reset_mid_R8();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule